// File: doc/BRIEF.md
# Drift-Compensated Delay Line Load Sequencer

This block programs a pair of cascaded tap-based delay stages whose tap size wanders with voltage and temperature. While idle it keeps the voltage/temperature tracking enable of both stages high. Each stage starts out holding a known non-zero base delay. The tap count that the first stage reports back therefore shows how many taps currently make up that base delay. When a requester asks for a new delay in picoseconds, the block first checks that the measured tap size is plausible. It then works out the tap count with a serial divider and loads that count into the stages. Each load is wrapped in a timed window during which tracking is suspended.

The requester presents a delay on `req_dly_ps` and pulses `req_valid` while `busy` is low. The block latches the request, the base delay and the read-back count. It computes `q = round(req_dly_ps * rb_count / base_dly_ps)`. If `q` fits in one stage, it loads only the first stage. Otherwise it splits the request evenly and loads both stages, one after the other. `done` pulses once per accepted request, and `cal_err` reports a rejected calibration.

The states are IDLE, CHECK, DIV, DROP, LOAD, HOLD and FINISH.
- IDLE to CHECK: on an accepted request.
- CHECK to FINISH: when the calibration is invalid.
- CHECK to DIV: when the calibration is valid.
- DIV to DROP: when the quotient is ready.
- DROP to LOAD: after WAIT_CYC cycles.
- LOAD to HOLD: after one cycle.
- HOLD to DROP (second stage): when a split is pending.
- HOLD to FINISH: otherwise.
- FINISH to IDLE: after one cycle.

Top module: `dly_update_seq`

## Requirements
- R1: Out of reset and whenever `busy` is low, `vt_en` is 2'b11, `load_stb` is 2'b00 and `done` is 0.
- R2: For a stage being loaded, `vt_en[s]` goes low and stays low for exactly WAIT_CYC (default 10) clock cycles before the single cycle in which `load_stb[s]` is high. `vt_en[s]` stays low during that cycle.
- R3: After the load cycle, `vt_en[s]` stays low for exactly WAIT_CYC more cycles and then returns high, so each low window lasts 2*WAIT_CYC+1 cycles.
- R4: The tap count is q = floor((req_dly_ps*rb_count + floor(base_dly_ps/2)) / base_dly_ps), that is, the quotient rounded to nearest, with ties rounded up.
- R5: When q <= 511, only stage 0 (bit 0 of `vt_en` and `load_stb`) is loaded, with `load_val` = q, and stage 1 is left untouched.
- R6: When q > 511, both stages are loaded with min(511, ceil(q/2)). Stage 0 is loaded first, and at no time are both `vt_en` bits low together.
- R7: The measured tap size in half-picoseconds must satisfy 5*rb_count <= 2*base_dly_ps <= 30*rb_count (2.5 ps to 15 ps). If it does not, `cal_err` is 1 when `done` pulses and no `load_stb` occurs.
- R8: A zero `rb_count` or a zero `base_dly_ps` raises `cal_err` at `done` and causes no load.
- R9: `busy` rises the cycle after an accepted request and stays high until `done`, which is high for one cycle. A `req_valid` seen while `busy` is high causes no load and no extra `done`.
- R10: `cal_err` clears when the next request is accepted, and it stays 0 through a valid sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided clock that times the sequence |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request pulse, accepted only when not busy |
| req_dly_ps | input | 16 | Requested delay in picoseconds |
| base_dly_ps | input | 16 | Fixed initial delay held by the stages, in picoseconds |
| rb_count | input | 9 | Tap count read back from stage 0 |
| vt_en | output | 2 | Per-stage voltage/temperature tracking enable |
| load_val | output | 9 | Tap count to load |
| load_stb | output | 2 | Per-stage load strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| cal_err | output | 1 | Calibration rejected for the last request |

## Verification
The checker assumes that `req_valid` is a clean synchronous input. It also assumes that `base_dly_ps` and `rb_count` are stable in the cycle in which a request is accepted, because the block latches them there and never looks at them again. The stimulus drives every input at the falling edge and holds the values steady through acceptance. It changes them only while the block is busy, to show that they are ignored. Base delays and read-back counts are chosen both inside and outside the tap-size window, including the exact edge values, so that the error path and the load path are both reached.

// File: rtl/dly_seq_pkg.sv
package dly_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_DIV,
        ST_DROP,
        ST_LOAD,
        ST_HOLD,
        ST_FINISH
    } seq_state_t;
endpackage

// File: rtl/dly_tap_window.sv
module dly_tap_window #(
    parameter int DLY_W       = 16,
    parameter int CNT_W       = 9,
    parameter int TAP_MIN_HPS = 5,
    parameter int TAP_MAX_HPS = 30
) (
    input  logic [DLY_W-1:0] base_ps,
    input  logic [CNT_W-1:0] rb_cnt,
    output logic             ok
);
    localparam int P_W = DLY_W + CNT_W + 6;

    logic [P_W-1:0] base_x2;
    logic [P_W-1:0] lo_lim;
    logic [P_W-1:0] hi_lim;

    always_comb begin
        base_x2 = P_W'(base_ps) << 1;
        lo_lim  = P_W'(TAP_MIN_HPS) * P_W'(rb_cnt);
        hi_lim  = P_W'(TAP_MAX_HPS) * P_W'(rb_cnt);
        ok      = (rb_cnt != '0) && (base_ps != '0) &&
                  (base_x2 >= lo_lim) && (base_x2 <= hi_lim);
    end
endmodule

// File: rtl/dly_serial_div.sv
module dly_serial_div #(
    parameter int NUM_W = 26,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             fin,
    output logic [NUM_W-1:0] quo
);
    localparam int IT_W = $clog2(NUM_W + 1);

    logic [DEN_W:0]   rem_q;
    logic [NUM_W-1:0] quo_q;
    logic [IT_W-1:0]  it_q;
    logic             run_q;
    logic             fin_q;
    logic [DEN_W:0]   shifted;
    logic             take;

    always_comb begin
        shifted = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
        take    = shifted >= {1'b0, den};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            it_q  <= '0;
            run_q <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (start) begin
                rem_q <= '0;
                quo_q <= num;
                it_q  <= IT_W'(NUM_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= take ? (shifted - {1'b0, den}) : shifted;
                quo_q <= {quo_q[NUM_W-2:0], take};
                it_q  <= it_q - 1'b1;
                if (it_q == IT_W'(1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign fin = fin_q;
    assign quo = quo_q;
endmodule

// File: rtl/dly_split_plan.sv
module dly_split_plan #(
    parameter int NUM_W = 26,
    parameter int CNT_W = 9
) (
    input  logic [NUM_W-1:0] quo,
    output logic [CNT_W-1:0] cnt_a,
    output logic [CNT_W-1:0] cnt_b,
    output logic             split
);
    localparam logic [NUM_W-1:0] MAX_CNT = NUM_W'((1 << CNT_W) - 1);

    logic [NUM_W-1:0] half;

    always_comb begin
        half = (quo + 1'b1) >> 1;
        if (quo <= MAX_CNT) begin
            split = 1'b0;
            cnt_a = quo[CNT_W-1:0];
            cnt_b = '0;
        end else begin
            split = 1'b1;
            cnt_a = (half > MAX_CNT) ? MAX_CNT[CNT_W-1:0] : half[CNT_W-1:0];
            cnt_b = cnt_a;
        end
    end
endmodule

// File: rtl/dly_update_seq.sv
module dly_update_seq
    import dly_seq_pkg::*;
#(
    parameter int DLY_W       = 16,
    parameter int CNT_W       = 9,
    parameter int WAIT_CYC    = 10,
    parameter int TAP_MIN_HPS = 5,
    parameter int TAP_MAX_HPS = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [DLY_W-1:0] req_dly_ps,
    input  logic [DLY_W-1:0] base_dly_ps,
    input  logic [CNT_W-1:0] rb_count,
    output logic [1:0]       vt_en,
    output logic [CNT_W-1:0] load_val,
    output logic [1:0]       load_stb,
    output logic             busy,
    output logic             done,
    output logic             cal_err
);
    localparam int NUM_W  = DLY_W + CNT_W + 1;
    localparam int WCNT_W = $clog2(WAIT_CYC + 1);
    localparam logic [WCNT_W-1:0] WAIT_LAST = WCNT_W'(WAIT_CYC - 1);

    seq_state_t       state;
    logic [DLY_W-1:0] req_q;
    logic [DLY_W-1:0] base_q;
    logic [CNT_W-1:0] rb_q;
    logic [CNT_W-1:0] cnt_a_q;
    logic [CNT_W-1:0] cnt_b_q;
    logic             split_q;
    logic             stage_q;
    logic [WCNT_W-1:0] wcnt_q;
    logic             err_q;

    logic             win_ok;
    logic             div_start;
    logic [NUM_W-1:0] div_num;
    logic             div_fin;
    logic [NUM_W-1:0] div_quo;
    logic [CNT_W-1:0] plan_a;
    logic [CNT_W-1:0] plan_b;
    logic             plan_split;

    dly_tap_window #(
        .DLY_W(DLY_W), .CNT_W(CNT_W),
        .TAP_MIN_HPS(TAP_MIN_HPS), .TAP_MAX_HPS(TAP_MAX_HPS)
    ) u_win (
        .base_ps (base_q),
        .rb_cnt  (rb_q),
        .ok      (win_ok)
    );

    assign div_start = (state == ST_CHECK) && win_ok;
    assign div_num   = NUM_W'(req_q) * NUM_W'(rb_q) + NUM_W'(base_q >> 1);

    dly_serial_div #(.NUM_W(NUM_W), .DEN_W(DLY_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (base_q),
        .fin   (div_fin),
        .quo   (div_quo)
    );

    dly_split_plan #(.NUM_W(NUM_W), .CNT_W(CNT_W)) u_plan (
        .quo   (div_quo),
        .cnt_a (plan_a),
        .cnt_b (plan_b),
        .split (plan_split)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            req_q   <= '0;
            base_q  <= '0;
            rb_q    <= '0;
            cnt_a_q <= '0;
            cnt_b_q <= '0;
            split_q <= 1'b0;
            stage_q <= 1'b0;
            wcnt_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q  <= req_dly_ps;
                        base_q <= base_dly_ps;
                        rb_q   <= rb_count;
                        err_q  <= 1'b0;
                        state  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!win_ok) begin
                        err_q <= 1'b1;
                        state <= ST_FINISH;
                    end else begin
                        state <= ST_DIV;
                    end
                end
                ST_DIV: begin
                    if (div_fin) begin
                        cnt_a_q <= plan_a;
                        cnt_b_q <= plan_b;
                        split_q <= plan_split;
                        stage_q <= 1'b0;
                        wcnt_q  <= '0;
                        state   <= ST_DROP;
                    end
                end
                ST_DROP: begin
                    if (wcnt_q == WAIT_LAST) begin
                        wcnt_q <= '0;
                        state  <= ST_LOAD;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                ST_LOAD: begin
                    wcnt_q <= '0;
                    state  <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (wcnt_q == WAIT_LAST) begin
                        wcnt_q <= '0;
                        if (split_q && !stage_q) begin
                            stage_q <= 1'b1;
                            state   <= ST_DROP;
                        end else begin
                            state <= ST_FINISH;
                        end
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        vt_en    = 2'b11;
        load_stb = 2'b00;
        if (state == ST_DROP || state == ST_LOAD || state == ST_HOLD) begin
            vt_en[stage_q] = 1'b0;
        end
        if (state == ST_LOAD) begin
            load_stb[stage_q] = 1'b1;
        end
        load_val = stage_q ? cnt_b_q : cnt_a_q;
        busy     = (state != ST_IDLE);
        done     = (state == ST_FINISH);
        cal_err  = err_q;
    end
endmodule

// File: rtl/dly_update_seq_chk.sv
module dly_update_seq_chk #(
    parameter int CNT_W    = 9,
    parameter int WAIT_CYC = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] vt_en,
    input logic [1:0] load_stb,
    input logic       busy,
    input logic       done,
    input logic       cal_err
);
    localparam int RUN_W = $clog2(2 * WAIT_CYC + 3) + 1;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (vt_en == 2'b11 && load_stb == 2'b00 && !done));

    // R6
    one_stage_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~vt_en) <= 1) && $onehot0(load_stb));

    // R7
    err_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_err |-> (load_stb == 2'b00));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    for (genvar s = 0; s < 2; s++) begin : g_stage
        logic [RUN_W-1:0] low_run;

        always_ff @(posedge clk) begin
            if (!rst_n) low_run <= '0;
            else if (!vt_en[s]) low_run <= low_run + 1'b1;
            else low_run <= '0;
        end

        // R2
        stb_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load_stb[s] |-> (!vt_en[s] && low_run == RUN_W'(WAIT_CYC)));

        // R3
        relock_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vt_en[s] && low_run != '0) |-> (low_run == RUN_W'(2 * WAIT_CYC + 1)));
    end
endmodule

bind dly_update_seq dly_update_seq_chk #(.CNT_W(CNT_W), .WAIT_CYC(WAIT_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .vt_en     (vt_en),
    .load_stb  (load_stb),
    .busy      (busy),
    .done      (done),
    .cal_err   (cal_err)
);

// File: tb/dly_update_seq_bench.sv
module dly_update_seq_bench;
    localparam int WAIT_CYC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_dly_ps = '0;
    logic [15:0] base_dly_ps = '0;
    logic [8:0]  rb_count = '0;
    logic [1:0]  vt_en;
    logic [8:0]  load_val;
    logic [1:0]  load_stb;
    logic        busy;
    logic        done;
    logic        cal_err;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int low_run[2] = '{0, 0};
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dly_update_seq u_dly_update_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_dly_ps(req_dly_ps), .base_dly_ps(base_dly_ps), .rb_count(rb_count),
        .vt_en(vt_en), .load_val(load_val), .load_stb(load_stb),
        .busy(busy), .done(done), .cal_err(cal_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pops expected loads and checks the timing of each window (R2, R3, R4, R5, R6)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int s = 0; s < 2; s++) begin
                if (!vt_en[s]) begin
                    if (load_stb[s]) begin
                        int got;
                        got = s * 1024 + int'(load_val);
                        chk(low_run[s] == WAIT_CYC, "R2 wait before load", low_run[s], WAIT_CYC);
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R9/R5 unexpected load", got, -1);
                        end else begin
                            int e;
                            e = exp_q.pop_front();
                            chk(got == e, "R4/R6 stage*1024+count", got, e);
                        end
                    end
                    low_run[s]++;
                end else begin
                    if (low_run[s] != 0)
                        chk(low_run[s] == 2 * WAIT_CYC + 1, "R3 low window", low_run[s], 2 * WAIT_CYC + 1);
                    low_run[s] = 0;
                end
            end
        end
    end

    // Driver: computes expected loads and pushes them before launching the request
    task automatic run_req(input int req, input int rb, input int base,
                           input bit exp_err, input bit inject, input string tag);
        longint q;
        int h;
        int guard;
        if (!exp_err) begin
            q = (longint'(req) * rb + base / 2) / base;
            if (q <= 511) begin
                exp_q.push_back(int'(q));
            end else begin
                h = int'((q + 1) / 2);
                if (h > 511) h = 511;
                exp_q.push_back(h);
                exp_q.push_back(1024 + h);
            end
        end
        @(negedge clk);
        req_dly_ps  = 16'(req);
        rb_count    = 9'(rb);
        base_dly_ps = 16'(base);
        req_valid   = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
        if (inject) begin
            repeat (5) @(negedge clk);
            chk(busy == 1'b1, "R9 busy mid sequence", int'(busy), 1);
            req_dly_ps  = 16'd3000;
            rb_count    = 9'd300;
            base_dly_ps = 16'd700;
            req_valid   = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        guard = 0;
        while (!done && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(done == 1'b1, {tag, " R9 done seen"}, int'(done), 1);
        chk(cal_err == exp_err, {tag, " R7/R8/R10 cal_err"}, int'(cal_err), int'(exp_err));
        chk(exp_q.size() == 0, {tag, " R5/R6 loads outstanding"}, exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, {tag, " R9 single done"}, int'({done, busy}), 0);
        chk(vt_en == 2'b11, {tag, " R1 tracking restored"}, int'(vt_en), 3);
        repeat (3) @(negedge clk);
        chk(done == 1'b0, {tag, " R9 no extra done"}, int'(done), 0);
    endtask

    initial begin
        #(8 * 150000);
        chk(1'b0, "R9 watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(vt_en == 2'b11 && load_stb == 2'b00, "R1 reset outputs", int'({vt_en, load_stb}), 12);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && cal_err == 1'b0, "R1 idle flags", int'({busy, done, cal_err}), 0);

        run_req(800, 160, 800, 1'b0, 1'b0, "R5 single 160");
        run_req(805, 100, 800, 1'b0, 1'b0, "R4 round up 101");
        run_req(2555, 160, 800, 1'b0, 1'b0, "R5 edge 511");
        run_req(2560, 160, 800, 1'b0, 1'b0, "R6 edge 512 split");
        run_req(5000, 160, 800, 1'b0, 1'b0, "R6 split 500");
        run_req(4005, 160, 800, 1'b0, 1'b0, "R6 odd split 401");
        run_req(10000, 320, 800, 1'b0, 1'b0, "R6 saturate 511");
        run_req(100, 320, 800, 1'b0, 1'b0, "R7 min tap edge ok");
        run_req(100, 321, 800, 1'b1, 1'b0, "R7 tap below min");
        run_req(900, 54, 800, 1'b0, 1'b0, "R10 max tap edge ok after err");
        run_req(900, 53, 800, 1'b1, 1'b0, "R7 tap above max");
        run_req(500, 0, 800, 1'b1, 1'b0, "R8 zero readback");
        run_req(500, 100, 0, 1'b1, 1'b0, "R8 zero base");
        run_req(1200, 200, 1000, 1'b0, 1'b1, "R9 ignore while busy");
        run_req(6000, 200, 1000, 1'b0, 1'b1, "R9 ignore while busy split");

        repeat (10) @(negedge clk);
        chk(vt_en == 2'b11 && load_stb == 2'b00 && !busy, "R1 final idle", int'({vt_en, load_stb}), 12);
        summary();
    end
endmodule